// File: doc/BRIEF.md
# Pseudo-Carry Parallel-Prefix Adder

This block adds two unsigned binary operands of a parameterized width (8, 16, 32 or 64 bits) in pure combinational logic. It returns a sum of the same width and a carry-out. There is no carry-in. The result is valid one settling time after the operands change.

The adder is built in three stages. The first stage forms, for each bit, a generate term (AND of the operand bits) and a propagate term. The propagate term is the OR of the operand bits, not their XOR. Each bit is then merged with its lower neighbour into a paired term: paired generate is g_i OR g_{i-1}, and paired propagate is p_{i-1} AND p_{i-2}. Positions below bit 0 count as generate 0 and propagate 1.

The second stage is a doubling-span prefix network over these pairs, with log2(WIDTH) - 1 levels. It produces a pseudo-carry k_i = g_i OR c_{i-1} at each bit, not the true carry c_i. The true carry is recovered as k_i AND p_i. The last stage picks each sum bit with a 2:1 multiplexer steered by k_{i-1}. The two choices are the half-sum (NOT g_i) AND p_i, and that half-sum XORed with p_{i-1}.

Top module: `pseudo_carry_adder`

## Requirements
- R1: For every pair of operands, the concatenation {carry_out, sum_out} equals the unsigned WIDTH+1-bit value a_in + b_in. The output follows the inputs with no clock.
- R2: Sum bit 0 equals a_in[0] XOR b_in[0], because there is no carry-in; operands 0 and 0 give sum 0 and carry-out 0.
- R3: When both operand MSBs are 0, carry_out is 0. This holds even when a carry ripples up to the MSB (for example 0111…1 + 1 gives 1000…0 with carry_out 0).
- R4: When both operand MSBs are 1, carry_out is 1 (for example 1000…0 + 1000…0 gives sum 0, carry_out 1).
- R5: A carry born at bit 0 travels through every bit: all-ones + 1 gives sum 0 and carry_out 1.
- R6: The true carry out of bit i is the pseudo-carry k_i ANDed with p_i, where k_i = g_i OR (true carry into bit i). A set pseudo-carry over a bit whose operand bits are both 0 must not flip the next sum bit (5 + 1 = 6).
- R7: The same design is correct at widths 8, 32 and 64. The prefix network has log2(WIDTH) - 1 levels of span-doubling cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| sum_out | output | WIDTH | Low WIDTH bits of a_in + b_in |
| carry_out | output | 1 | Carry out of the MSB |

## Verification
A carry can be lost where a pseudo-carry is set over a bit pair that is 0/0. A design that forgot to mask k with p there would flip the next sum bit, and it would also raise carry_out when 0111…1 + 1 reaches the MSB. The full-length chain all-ones + 1 catches a prefix network that is one level short, or that has a wrong span at the top level; such a design would drop the carry in the upper half. The 8-bit width is swept exhaustively. At 32 and 64 bits, directed corners and random operands catch boundary mistakes at bit 0 and at the MSB that only appear at the larger widths.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef struct packed {
    logic gen;
    logic prp;
  } gp_t;

  // Associative prefix operator: upper node absorbs the lower node.
  function automatic gp_t gp_merge(gp_t upper, gp_t lower);
    gp_t r;
    r.gen = upper.gen | (upper.prp & lower.gen);
    r.prp = upper.prp & lower.prp;
    return r;
  endfunction

  // Half-sum with OR-propagate: true only when exactly one operand bit is set.
  function automatic logic half_sum(logic g, logic p);
    return ~g & p;
  endfunction

  // Sum-bit selector steered by the pseudo-carry of the bit below.
  function automatic logic sum_pick(logic g, logic p, logic p_below, logic k_below);
    logic h;
    h = half_sum(g, p);
    return k_below ? (h ^ p_below) : h;
  endfunction

endpackage

// File: rtl/ppa_precompute.sv
module ppa_precompute
  import ppa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prp,
  output gp_t  [WIDTH-1:0] pair
);

  assign gen = a & b;
  assign prp = a | b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    logic gen_lo;
    logic prp_lo1;
    logic prp_lo2;
    if (i >= 1) begin : g_has1
      assign gen_lo  = gen[i-1];
      assign prp_lo1 = prp[i-1];
    end else begin : g_no1
      assign gen_lo  = 1'b0;
      assign prp_lo1 = 1'b1;
    end
    if (i >= 2) begin : g_has2
      assign prp_lo2 = prp[i-2];
    end else begin : g_no2
      assign prp_lo2 = 1'b1;
    end
    assign pair[i].gen = gen[i] | gen_lo;
    assign pair[i].prp = prp_lo1 & prp_lo2;
  end

endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree
  import ppa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  gp_t  [WIDTH-1:0] pair,
  output logic [WIDTH-1:0] pk
);

  localparam int LEVELS = $clog2(WIDTH) - 1;

  gp_t [WIDTH-1:0] node [0:LEVELS];

  assign node[0] = pair;

  for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_level
    localparam int SPAN = 1 << lv;
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      if (i >= SPAN) begin : g_black
        assign node[lv][i] = gp_merge(node[lv-1][i], node[lv-1][i-SPAN]);
      end else begin : g_white
        assign node[lv][i] = node[lv-1][i];
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign pk[i] = node[LEVELS][i].gen;
  end

endmodule

// File: rtl/ppa_result.sv
module ppa_result
  import ppa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] prp,
  input  logic [WIDTH-1:0] pk,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] carry,
  output logic             cout
);

  assign sum[0] = half_sum(gen[0], prp[0]);

  for (genvar i = 1; i < WIDTH; i++) begin : g_sum
    assign sum[i] = sum_pick(gen[i], prp[i], prp[i-1], pk[i-1]);
  end

  assign carry = pk & prp;
  assign cout  = pk[WIDTH-1] & prp[WIDTH-1];

endmodule

// File: rtl/pseudo_carry_adder.sv
module pseudo_carry_adder
  import ppa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  logic [WIDTH-1:0] gen_w;
  logic [WIDTH-1:0] prp_w;
  gp_t  [WIDTH-1:0] pair_w;
  logic [WIDTH-1:0] pseudo_c;
  logic [WIDTH-1:0] true_c;

  ppa_precompute #(.WIDTH(WIDTH)) u_pre (
    .a    (a_in),
    .b    (b_in),
    .gen  (gen_w),
    .prp  (prp_w),
    .pair (pair_w)
  );

  ppa_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .pair (pair_w),
    .pk   (pseudo_c)
  );

  ppa_result #(.WIDTH(WIDTH)) u_res (
    .gen   (gen_w),
    .prp   (prp_w),
    .pk    (pseudo_c),
    .sum   (sum_out),
    .carry (true_c),
    .cout  (carry_out)
  );

endmodule

// File: rtl/pseudo_carry_adder_chk.sv
module pseudo_carry_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [WIDTH-1:0] gen,
  input logic [WIDTH-1:0] pk,
  input logic [WIDTH-1:0] tc
);

  logic [WIDTH:0] total;
  logic [WIDTH:0] cin_vec;

  assign total   = {1'b0, a} + {1'b0, b};
  assign cin_vec = total ^ {1'b0, a ^ b};

  always_comb begin
    // R1
    sum_match_chk: assert ({cout, sum} == total)
      else $error("R1 sum mismatch");
    // R2
    lsb_sum_chk: assert (sum[0] == (a[0] ^ b[0]))
      else $error("R2 bit0 mismatch");
    // R3
    msb_quiet_chk: assert ((a[WIDTH-1] | b[WIDTH-1]) || !cout)
      else $error("R3 spurious carry-out");
    // R4
    msb_gen_chk: assert (!(a[WIDTH-1] & b[WIDTH-1]) || cout)
      else $error("R4 missing carry-out");
    for (int i = 0; i < WIDTH; i++) begin
      // R6
      true_carry_chk: assert (tc[i] == cin_vec[i+1])
        else $error("R6 true carry mismatch at %0d", i);
      // R6
      pseudo_carry_chk: assert (pk[i] == (gen[i] | ((i > 0) ? cin_vec[i] : 1'b0)))
        else $error("R6 pseudo-carry mismatch at %0d", i);
    end
  end

endmodule

bind pseudo_carry_adder pseudo_carry_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a    (a_in),
  .b    (b_in),
  .sum  (sum_out),
  .cout (carry_out),
  .gen  (gen_w),
  .pk   (pseudo_c),
  .tc   (true_c)
);

// File: tb/pseudo_carry_adder_tb.sv
module pseudo_carry_adder_tb;

  typedef struct {
    int          width;
    logic [64:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  a8  = '0, b8  = '0, s8;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic [63:0] a64 = '0, b64 = '0, s64;
  logic c8, c32, c64;

  pseudo_carry_adder #(.WIDTH(8))  u_dut8  (.a_in(a8),  .b_in(b8),  .sum_out(s8),  .carry_out(c8));
  pseudo_carry_adder #(.WIDTH(32)) u_dut   (.a_in(a32), .b_in(b32), .sum_out(s32), .carry_out(c32));
  pseudo_carry_adder #(.WIDTH(64)) u_dut64 (.a_in(a64), .b_in(b64), .sum_out(s64), .carry_out(c64));

  item_t sb[$];
  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  function automatic logic [63:0] wmask(int w);
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  task automatic drive(int w, logic [63:0] a, logic [63:0] b, string tag);
    item_t it;
    logic [63:0] am, bm;
    @(posedge clk);
    am = a & wmask(w);
    bm = b & wmask(w);
    case (w)
      8:       begin a8  = am[7:0];  b8  = bm[7:0];  end
      32:      begin a32 = am[31:0]; b32 = bm[31:0]; end
      default: begin a64 = am;       b64 = bm;       end
    endcase
    it.width = w;
    it.exp   = {1'b0, am} + {1'b0, bm};
    it.tag   = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [64:0] got;
      it = sb.pop_front();
      case (it.width)
        8:       got = {56'b0, c8, s8};
        32:      got = {32'b0, c32, s32};
        default: got = {c64, s64};
      endcase
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s width %0d: got %h expected %h", it.tag, it.width, got, it.exp);
      end
    end
  end

  task automatic corners(int w, string wtag);
    logic [63:0] m;
    m = wmask(w);
    drive(w, 64'd0, 64'd0, "R2");                         // zero operands
    drive(w, 64'd1, 64'd0, "R2");
    drive(w, m >> 1, 64'd1, "R3");                        // ripple to MSB, no cout
    drive(w, m >> 1, m >> 1, "R3");
    drive(w, (m >> 1) + 64'd1, (m >> 1) + 64'd1, "R4");   // both MSBs set
    drive(w, m, m, "R4");
    drive(w, m, 64'd1, "R5");                             // full-length chain
    drive(w, 64'd1, m, "R5");
    drive(w, 64'd5, 64'd1, "R6");                         // k set over a 0/0 pair
    drive(w, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, "R6");
    for (int i = 0; i < 1500; i++)
      drive(w, {$urandom, $urandom}, {$urandom, $urandom}, wtag);
  endtask

  initial begin
    // R1: exhaustive 8-bit sweep
    for (int x = 0; x < 65536; x++)
      drive(8, {56'b0, x[15:8]}, {56'b0, x[7:0]}, "R1");
    // R7: corners and random vectors at the wider widths
    corners(8, "R7");
    corners(32, "R7");
    corners(64, "R7");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    #5;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule